// File: doc/BRIEF.md
# Resizable Direct-Mapped Instruction Cache with Freeze

This block sits between an instruction fetch port and a next-level memory port. It holds one local program array. Part of that array is used as a direct-mapped instruction cache, and the rest is plain RAM that is read by address. The cache share is picked at run time from five settings: none, one eighth, one quarter, one half or all of the array. With `NUM_LINES = 1024` the array is 32 KB and the settings give 0, 4, 8, 16 and 32 KB. The default parameters build a 1 KB array, which keeps elaboration and the bench small.

A fetch that falls in the RAM part is answered from the array. A cacheable fetch that hits is answered from the cache line. A cacheable fetch that misses requests the whole 32-byte line from the next level. The line arrives as eight 32-bit beats and the fetch is answered after the last beat. Three controls change how lines are kept:
- Freeze keeps the current lines. A frozen miss is still served from below, but nothing is written into the array.
- A global invalidate clears every valid bit.
- A change of cache size clears every valid bit, and fetches are stalled while the change takes place.

Top module: `frz_icache`

## Requirements
- R1: A cacheable fetch to a line that is resident and valid returns the addressed word with no next-level request. The response `fch_rvalid` is high in the second cycle after the accepting edge.
- R2: A cacheable miss makes exactly one next-level request at the line-aligned address (low 5 address bits zero). The address is held stable until it is accepted. The line is then taken as 8 beats, beat k being byte offset 4k, and the requested word is returned after the last beat.
- R3: Placement is direct-mapped. With C cache lines and R = NUM_LINES − C RAM lines, the line address L uses slot R + (L mod C). Only line L can hit in that slot, and a fetch of a different line with the same index evicts it.
- R4: `size_sel` chooses C = 0, NUM_LINES/8, /4, /2 or NUM_LINES for codes 0 to 4. A fetch whose address is below R×32 bytes reads array word addr[..:2] directly, with no next-level request. It returns whatever that word last received from a line fill.
- R5: When `size_sel` changes, `fch_rdy` is low for two cycles: the cycle of the change and the one after. All lines are invalid afterwards.
- R6: While `freeze` is high, a miss still fetches the line and returns the correct word, but it writes no data, tag or valid bit. A later fetch to that line misses again, and the line that was resident still hits.
- R7: A one-cycle pulse on `inv_all` invalidates every line. `fch_rdy` is low in the cycle after the pulse, and every later cacheable fetch misses until its line is refilled.
- R8: With code 0 (no cache), every fetch at or above the array size goes to the next level, including repeated fetches of the same line.
- R9: Codes 5, 6 and 7 behave as code 4 (whole array is cache).
- R10: Only one fetch is outstanding. After an accepting edge, `fch_rdy` and `nl_req_valid` are low in the following cycle.
- R11: Every accepted fetch gets exactly one response, and `fch_rvalid` is high for one cycle.
- R12: After reset the size setting is code 0, no line is valid, and the block is ready with no response and no next-level request pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| size_sel | input | 3 | Cache size code (0..4, 5..7 = 4) |
| freeze | input | 1 | Keep contents; misses do not allocate |
| inv_all | input | 1 | Pulse to invalidate every line |
| fch_req | input | 1 | Fetch request |
| fch_addr | input | ADDR_W | Fetch byte address |
| fch_rdy | output | 1 | Fetch accepted when high with fch_req |
| fch_rvalid | output | 1 | Fetch response valid (one cycle) |
| fch_rdata | output | DATA_W | Fetch response word |
| nl_req_valid | output | 1 | Next-level line request |
| nl_req_ready | input | 1 | Next level accepts the request |
| nl_req_addr | output | ADDR_W | Line-aligned request address |
| nl_rvalid | input | 1 | Next-level beat valid |
| nl_rdata | input | DATA_W | Next-level beat data |
| nl_rready | output | 1 | Block accepts beats |

## Verification
The assertions assume three things about the inputs:
- `size_sel` is held steady through reset and is only changed while no fetch is in flight.
- `nl_rvalid` is raised only while `nl_rready` is high.
- The next level delivers a line only after it has accepted the request for it.

The bench drives the next level from a responder that waits for the request, grants it with a variable delay and then sends eight beats with gaps between some of them. It changes the size only between completed fetches, and it changes it only to a code whose normalised value differs from the current one, so the stall check always applies.

// File: rtl/icache_pkg.sv
package icache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SWITCH,
    ST_LOOK,
    ST_REQ,
    ST_FILL
  } ic_state_t;

  // Codes above 4 select the whole array as cache.
  function automatic logic [2:0] ic_norm_size(input logic [2:0] s);
    return (s > 3'd4) ? 3'd4 : s;
  endfunction

endpackage

// File: rtl/ic_data_ram.sv
module ic_data_ram #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ic_tag_store.sv
module ic_tag_store #(
  parameter int SLOTS = 32,
  parameter int TAG_W = 25
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr_all,
  input  logic                     wr_en,
  input  logic [$clog2(SLOTS)-1:0] wr_slot,
  input  logic [TAG_W-1:0]         wr_tag,
  input  logic                     rd_en,
  input  logic [$clog2(SLOTS)-1:0] rd_slot,
  output logic [TAG_W-1:0]         rd_tag,
  output logic                     rd_valid
);
  logic [TAG_W-1:0] tags [SLOTS];
  logic [SLOTS-1:0] valid_q;

  // Tag array: plain synchronous RAM.
  always_ff @(posedge clk) begin
    if (wr_en) tags[wr_slot] <= wr_tag;
    if (rd_en) rd_tag <= tags[rd_slot];
  end

  // Valid bits in flops, so that all of them clear in one cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (clr_all)    valid_q <= '0;
      else if (wr_en) valid_q[wr_slot] <= 1'b1;
      if (rd_en) rd_valid <= valid_q[rd_slot];
    end
  end
endmodule

// File: rtl/ic_ctrl.sv
module ic_ctrl
  import icache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 8,
  parameter int NUM_LINES  = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [2:0]             size_sel,
  input  logic                   freeze,
  input  logic                   inv_all,
  input  logic                   fch_req,
  input  logic [ADDR_W-1:0]      fch_addr,
  output logic                   fch_rdy,
  output logic                   fch_rvalid,
  output logic [DATA_W-1:0]      fch_rdata,
  output logic                   nl_req_valid,
  input  logic                   nl_req_ready,
  output logic [ADDR_W-1:0]      nl_req_addr,
  input  logic                   nl_rvalid,
  input  logic [DATA_W-1:0]      nl_rdata,
  output logic                   nl_rready,
  // data array
  output logic                   d_we,
  output logic [$clog2(NUM_LINES)+$clog2(LINE_WORDS)-1:0] d_waddr,
  output logic [DATA_W-1:0]      d_wdata,
  output logic                   d_re,
  output logic [$clog2(NUM_LINES)+$clog2(LINE_WORDS)-1:0] d_raddr,
  input  logic [DATA_W-1:0]      d_rdata,
  // tag store
  output logic                   t_clr,
  output logic                   t_we,
  output logic [$clog2(NUM_LINES)-1:0] t_wslot,
  output logic [ADDR_W-$clog2(LINE_WORDS*DATA_W/8)-$clog2(NUM_LINES/8)-1:0] t_wtag,
  output logic                   t_re,
  output logic [$clog2(NUM_LINES)-1:0] t_rslot,
  input  logic [ADDR_W-$clog2(LINE_WORDS*DATA_W/8)-$clog2(NUM_LINES/8)-1:0] t_rtag,
  input  logic                   t_rvalid
);
  localparam int BOFF_W = $clog2(DATA_W/8);
  localparam int WOFF_W = $clog2(LINE_WORDS);
  localparam int OFF_W  = BOFF_W + WOFF_W;
  localparam int SLOT_W = $clog2(NUM_LINES);
  localparam int SW1    = SLOT_W + 1;
  localparam int LA_W   = ADDR_W - OFF_W;
  localparam int TAG_W  = LA_W - $clog2(NUM_LINES/8);
  localparam logic [WOFF_W-1:0] LAST_BEAT = WOFF_W'(LINE_WORDS - 1);

  ic_state_t st_q;
  logic [2:0]             cur_size_q;
  logic                   inv_pend_q;
  logic [ADDR_W-1:BOFF_W] addr_q;
  logic                   ram_q, byp_q, alloc_q;
  logic [SLOT_W-1:0]      slot_q;
  logic [WOFF_W-1:0]      beat_q;
  logic [DATA_W-1:0]      cap_q;

  // Address decode against the current split of the array.
  logic [SW1-1:0]    cache_lines, ram_lines;
  logic [LA_W-1:0]   line_addr;
  logic              in_ram;
  logic [SLOT_W-1:0] idx_mask, slot_d;

  always_comb begin
    case (cur_size_q)
      3'd0:    cache_lines = '0;
      3'd1:    cache_lines = SW1'(NUM_LINES / 8);
      3'd2:    cache_lines = SW1'(NUM_LINES / 4);
      3'd3:    cache_lines = SW1'(NUM_LINES / 2);
      default: cache_lines = SW1'(NUM_LINES);
    endcase
    ram_lines = SW1'(NUM_LINES) - cache_lines;
    line_addr = fch_addr[ADDR_W-1:OFF_W];
    in_ram    = line_addr < LA_W'(ram_lines);
    idx_mask  = SLOT_W'(cache_lines - 1'b1);
    slot_d    = SLOT_W'(ram_lines) + (line_addr[SLOT_W-1:0] & idx_mask);
  end

  logic accept, hit, beat_take, word_match;
  logic [TAG_W-1:0] req_tag;

  assign fch_rdy    = (st_q == ST_IDLE) && !inv_pend_q &&
                      (ic_norm_size(size_sel) == cur_size_q);
  assign accept     = fch_req && fch_rdy;
  assign req_tag    = addr_q[ADDR_W-1:ADDR_W-TAG_W];
  assign hit        = !byp_q && t_rvalid && (t_rtag == req_tag);
  assign beat_take  = (st_q == ST_FILL) && nl_rvalid;
  assign word_match = (beat_q == addr_q[OFF_W-1:BOFF_W]);

  // Array and tag access.
  assign d_re    = accept;
  assign d_raddr = in_ram ? fch_addr[OFF_W+SLOT_W-1:BOFF_W]
                          : {slot_d, fch_addr[OFF_W-1:BOFF_W]};
  assign d_we    = beat_take && alloc_q;
  assign d_waddr = {slot_q, beat_q};
  assign d_wdata = nl_rdata;
  assign t_re    = accept;
  assign t_rslot = slot_d;
  assign t_we    = beat_take && alloc_q && (beat_q == LAST_BEAT);
  assign t_wslot = slot_q;
  assign t_wtag  = req_tag;
  assign t_clr   = (st_q == ST_SWITCH) || ((st_q == ST_IDLE) && inv_pend_q);

  // Next-level side.
  assign nl_req_valid = (st_q == ST_REQ);
  assign nl_req_addr  = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign nl_rready    = (st_q == ST_FILL);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      cur_size_q <= 3'd0;
      inv_pend_q <= 1'b0;
      addr_q     <= '0;
      ram_q      <= 1'b0;
      byp_q      <= 1'b0;
      alloc_q    <= 1'b0;
      slot_q     <= '0;
      beat_q     <= '0;
      cap_q      <= '0;
      fch_rvalid <= 1'b0;
      fch_rdata  <= '0;
    end else begin
      fch_rvalid <= 1'b0;
      if (inv_all) inv_pend_q <= 1'b1;
      case (st_q)
        ST_IDLE: begin
          if (ic_norm_size(size_sel) != cur_size_q) begin
            st_q <= ST_SWITCH;
          end else if (inv_pend_q) begin
            inv_pend_q <= inv_all;
          end else if (fch_req) begin
            addr_q <= fch_addr[ADDR_W-1:BOFF_W];
            ram_q  <= in_ram;
            byp_q  <= !in_ram && (cache_lines == '0);
            slot_q <= slot_d;
            st_q   <= ST_LOOK;
          end
        end
        ST_SWITCH: begin
          cur_size_q <= ic_norm_size(size_sel);
          inv_pend_q <= inv_all;
          st_q       <= ST_IDLE;
        end
        ST_LOOK: begin
          if (ram_q || hit) begin
            fch_rvalid <= 1'b1;
            fch_rdata  <= d_rdata;
            st_q       <= ST_IDLE;
          end else begin
            alloc_q <= !freeze && !byp_q;
            st_q    <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (nl_req_ready) begin
            beat_q <= '0;
            st_q   <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (nl_rvalid) begin
            beat_q <= beat_q + 1'b1;
            if (word_match) cap_q <= nl_rdata;
            if (beat_q == LAST_BEAT) begin
              fch_rvalid <= 1'b1;
              fch_rdata  <= word_match ? nl_rdata : cap_q;
              st_q       <= ST_IDLE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/frz_icache.sv
module frz_icache #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 8,
  parameter int NUM_LINES  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        size_sel,
  input  logic              freeze,
  input  logic              inv_all,
  input  logic              fch_req,
  input  logic [ADDR_W-1:0] fch_addr,
  output logic              fch_rdy,
  output logic              fch_rvalid,
  output logic [DATA_W-1:0] fch_rdata,
  output logic              nl_req_valid,
  input  logic              nl_req_ready,
  output logic [ADDR_W-1:0] nl_req_addr,
  input  logic              nl_rvalid,
  input  logic [DATA_W-1:0] nl_rdata,
  output logic              nl_rready
);
  localparam int OFF_W  = $clog2(LINE_WORDS * DATA_W / 8);
  localparam int SLOT_W = $clog2(NUM_LINES);
  localparam int WA_W   = SLOT_W + $clog2(LINE_WORDS);
  localparam int TAG_W  = ADDR_W - OFF_W - $clog2(NUM_LINES / 8);

  logic              d_we, d_re;
  logic [WA_W-1:0]   d_waddr, d_raddr;
  logic [DATA_W-1:0] d_wdata, d_rdata;
  logic              t_clr, t_we, t_re, t_rvalid;
  logic [SLOT_W-1:0] t_wslot, t_rslot;
  logic [TAG_W-1:0]  t_wtag, t_rtag;

  ic_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .LINE_WORDS(LINE_WORDS), .NUM_LINES(NUM_LINES)
  ) u_ctrl (
    .clk(clk), .rst(rst), .size_sel(size_sel), .freeze(freeze),
    .inv_all(inv_all), .fch_req(fch_req), .fch_addr(fch_addr),
    .fch_rdy(fch_rdy), .fch_rvalid(fch_rvalid), .fch_rdata(fch_rdata),
    .nl_req_valid(nl_req_valid), .nl_req_ready(nl_req_ready),
    .nl_req_addr(nl_req_addr), .nl_rvalid(nl_rvalid), .nl_rdata(nl_rdata),
    .nl_rready(nl_rready),
    .d_we(d_we), .d_waddr(d_waddr), .d_wdata(d_wdata),
    .d_re(d_re), .d_raddr(d_raddr), .d_rdata(d_rdata),
    .t_clr(t_clr), .t_we(t_we), .t_wslot(t_wslot), .t_wtag(t_wtag),
    .t_re(t_re), .t_rslot(t_rslot), .t_rtag(t_rtag), .t_rvalid(t_rvalid)
  );

  ic_data_ram #(.AW(WA_W), .DW(DATA_W)) u_data (
    .clk(clk), .we(d_we), .waddr(d_waddr), .wdata(d_wdata),
    .re(d_re), .raddr(d_raddr), .rdata(d_rdata)
  );

  ic_tag_store #(.SLOTS(NUM_LINES), .TAG_W(TAG_W)) u_tag (
    .clk(clk), .rst(rst), .clr_all(t_clr),
    .wr_en(t_we), .wr_slot(t_wslot), .wr_tag(t_wtag),
    .rd_en(t_re), .rd_slot(t_rslot), .rd_tag(t_rtag), .rd_valid(t_rvalid)
  );
endmodule

// File: rtl/ic_checker.sv
module ic_checker
  import icache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        size_sel,
  input logic              fch_req,
  input logic              fch_rdy,
  input logic              fch_rvalid,
  input logic              nl_req_valid,
  input logic              nl_req_ready,
  input logic [ADDR_W-1:0] nl_req_addr,
  input logic              nl_rready
);
  AST_LOOKUP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (fch_req && fch_rdy) |=> (!fch_rdy && !nl_req_valid)); // R10

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (nl_req_valid && !nl_req_ready) |=> (nl_req_valid && $stable(nl_req_addr))); // R2

  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    nl_req_valid |-> (nl_req_addr[OFF_W-1:0] == '0)); // R2

  AST_RESP_AFTER_FILL: assert property (@(posedge clk) disable iff (rst)
    fch_rvalid |-> !nl_rready); // R2

  AST_SIZE_STALL: assert property (@(posedge clk) disable iff (rst)
    (ic_norm_size(size_sel) != ic_norm_size($past(size_sel))) |-> !fch_rdy); // R5

  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (rst)
    fch_rvalid |=> !fch_rvalid); // R11
endmodule

bind frz_icache ic_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst(rst), .size_sel(size_sel), .fch_req(fch_req),
  .fch_rdy(fch_rdy), .fch_rvalid(fch_rvalid), .nl_req_valid(nl_req_valid),
  .nl_req_ready(nl_req_ready), .nl_req_addr(nl_req_addr), .nl_rready(nl_rready)
);

// File: tb/sim_frz_icache.sv
`timescale 1ns/1ps
module sim_frz_icache;
  localparam int NL = 32;
  localparam int NW = NL * 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  size_sel = 3'd0;
  logic        freeze = 1'b0, inv_all = 1'b0, fch_req = 1'b0;
  logic [31:0] fch_addr = '0;
  logic        fch_rdy, fch_rvalid, nl_req_valid, nl_rready;
  logic [31:0] fch_rdata, nl_req_addr;
  logic        nl_req_ready = 1'b0, nl_rvalid = 1'b0;
  logic [31:0] nl_rdata = '0;

  int errors = 0, checks = 0, fills = 0;

  always #2 clk = ~clk;

  frz_icache u0 (
    .clk(clk), .rst(rst), .size_sel(size_sel), .freeze(freeze),
    .inv_all(inv_all), .fch_req(fch_req), .fch_addr(fch_addr),
    .fch_rdy(fch_rdy), .fch_rvalid(fch_rvalid), .fch_rdata(fch_rdata),
    .nl_req_valid(nl_req_valid), .nl_req_ready(nl_req_ready),
    .nl_req_addr(nl_req_addr), .nl_rvalid(nl_rvalid), .nl_rdata(nl_rdata),
    .nl_rready(nl_rready)
  );

  function automatic logic [31:0] mw(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'hC3A5_0F1E;
  endfunction

  // Bench model of the array, built from the requirements.
  int          msize = 0;
  logic [31:0] m_tag [NL];
  bit          m_val [NL];
  logic [31:0] amem [NW];
  bit          aknown [NW];

  function automatic int lines_of(input int code);
    case (code)
      0: return 0;
      1: return NL / 8;
      2: return NL / 4;
      3: return NL / 2;
      default: return NL;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Next-level responder.
  logic [31:0] la_r;
  initial begin
    forever begin
      @(negedge clk);
      if (nl_req_valid && !rst) begin
        la_r = nl_req_addr;
        if (fills % 2 == 1) @(negedge clk);
        nl_req_ready = 1'b1;
        @(negedge clk);
        nl_req_ready = 1'b0;
        fills++;
        for (int k = 0; k < 8; k++) begin
          if ((k + fills) % 3 == 0) @(negedge clk);
          nl_rvalid = 1'b1;
          nl_rdata  = mw(la_r + 32'(4 * k));
          @(negedge clk);
          nl_rvalid = 1'b0;
        end
      end
    end
  end

  // One fetch, with expected data, fill count and latency from the model.
  task automatic fetch(input logic [31:0] a, input string req);
    int cl, rl, slot, f0, n, expf;
    logic [31:0] la, expd;
    bit known, hit;
    cl = lines_of(msize);
    rl = NL - cl;
    la = a >> 5;
    known = 1'b1;
    hit = 1'b0;
    if (la < 32'(rl)) begin
      expf = 0;
      expd = amem[(a >> 2) % NW];
      known = aknown[(a >> 2) % NW];
      hit = 1'b1;
    end else if (cl == 0) begin
      expf = 1;
      expd = mw(a);
    end else begin
      slot = rl + int'(la % 32'(cl));
      hit  = m_val[slot] && (m_tag[slot] == la);
      expf = hit ? 0 : 1;
      expd = mw(a);
      if (!hit && !freeze) begin
        m_val[slot] = 1'b1;
        m_tag[slot] = la;
        for (int k = 0; k < 8; k++) begin
          amem[slot * 8 + k]   = mw((la << 5) + 32'(4 * k));
          aknown[slot * 8 + k] = 1'b1;
        end
      end
    end
    @(negedge clk);
    while (!fch_rdy) @(negedge clk);
    fch_req = 1'b1;
    fch_addr = a;
    f0 = fills;
    @(negedge clk);
    fch_req = 1'b0;
    n = 1;
    while (!fch_rvalid && n < 300) begin
      @(negedge clk);
      n++;
    end
    chk(fch_rvalid, {req, " response"}, 32'(fch_rvalid), 32'd1);
    if (known) chk(fch_rdata == expd, {req, " data"}, fch_rdata, expd);
    chk((fills - f0) == expf, {req, " next-level fills"}, 32'(fills - f0), 32'(expf));
    if (hit) chk(n == 2, {req, " R1 hit latency"}, 32'(n), 32'd2);
    @(negedge clk);
    chk(!fch_rvalid, "R11 single-cycle response", 32'(fch_rvalid), 32'd0);
  endtask

  task automatic set_size(input logic [2:0] code);
    @(negedge clk);
    size_sel = code;
    #0;
    chk(!fch_rdy, "R5 stall in change cycle", 32'(fch_rdy), 32'd0);
    @(negedge clk);
    chk(!fch_rdy, "R5 stall during switch", 32'(fch_rdy), 32'd0);
    @(negedge clk);
    chk(fch_rdy, "R5 ready after switch", 32'(fch_rdy), 32'd1);
    msize = (code > 3'd4) ? 4 : int'(code);
    for (int s = 0; s < NL; s++) m_val[s] = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int s = 0; s < NL; s++) m_val[s] = 1'b0;
    for (int w = 0; w < NW; w++) aknown[w] = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(fch_rdy, "R12 ready after reset", 32'(fch_rdy), 32'd1);
    chk(!fch_rvalid, "R12 no response after reset", 32'(fch_rvalid), 32'd0);
    chk(!nl_req_valid, "R12 no request after reset", 32'(nl_req_valid), 32'd0);

    // R8 no cache: every fetch goes below
    fetch(32'h0001_0004, "R8 bypass first");
    fetch(32'h0001_0004, "R8 bypass repeat");

    // R1 R2 full cache sweep, then hits
    set_size(3'd4);
    for (int i = 0; i < NL; i++) fetch(32'h0001_0000 + 32'(i * 32 + (i % 8) * 4), "R2 fill sweep");
    for (int i = 0; i < NL; i++) fetch(32'h0001_0000 + 32'(i * 32 + ((i + 3) % 8) * 4), "R1 hit sweep");

    // R3 direct-mapped conflicts
    for (int i = 0; i < 4; i++) fetch(32'h0001_0400 + 32'(i * 32), "R3 alias evict");
    for (int i = 0; i < 5; i++) fetch(32'h0001_0000 + 32'(i * 32 + 8), "R3 refetch");

    // R6 freeze
    @(negedge clk);
    freeze = 1'b1;
    fetch(32'h0002_0000, "R6 frozen miss");
    fetch(32'h0001_0004, "R6 resident still hits");
    fetch(32'h0002_001C, "R6 frozen line not kept");
    @(negedge clk);
    freeze = 1'b0;

    // R7 invalidate
    @(negedge clk);
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
    chk(!fch_rdy, "R7 stall after invalidate", 32'(fch_rdy), 32'd0);
    for (int s = 0; s < NL; s++) m_val[s] = 1'b0;
    fetch(32'h0001_0020, "R7 miss after invalidate");
    fetch(32'h0001_0024, "R7 refilled hit");

    // R4 smallest cache: RAM part and cache part
    set_size(3'd1);
    for (int w = 0; w < (NL - NL / 8) * 8; w++) fetch(32'(w * 4), "R4 RAM read");
    for (int i = 0; i < 8; i++) fetch(32'h0001_0000 + 32'(i * 32), "R4 R3 small cache");
    for (int i = 4; i < 8; i++) fetch(32'h0001_0000 + 32'(i * 32 + 12), "R4 small cache hit");

    // R9 code above 4 acts as full
    set_size(3'd6);
    fetch(32'h0000_0000, "R9 low address cacheable");
    fetch(32'h0000_0010, "R9 hit");
    fetch(32'h0000_03E0, "R9 top slot");

    // R4 other sizes
    set_size(3'd2);
    for (int i = 0; i < NL / 2; i++) fetch(32'h0003_0000 + 32'(i * 32 + 4), "R4 quarter cache");
    for (int w = 0; w < (NL - NL / 4) * 8; w += 5) fetch(32'(w * 4), "R4 RAM at quarter");
    set_size(3'd3);
    for (int i = 0; i < NL; i++) fetch(32'h0004_0000 + 32'(i * 32), "R4 half cache");
    for (int w = 0; w < (NL / 2) * 8; w += 3) fetch(32'(w * 4), "R4 RAM at half");

    // R8 all RAM again
    set_size(3'd0);
    for (int w = 0; w < NW; w += 7) fetch(32'(w * 4), "R8 R4 all RAM");
    fetch(32'h0004_0000, "R8 bypass after resize");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule